// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue and Split Interrupts

This block recovers asynchronous serial frames from one idle-high input line and places each received character in a small on-chip queue, together with two status bits that say whether that character had a parity fault or a bad stop bit. It oversamples the line with an enable tick running at sixteen times the bit rate. A start bit is accepted only if the line is still low at the middle of that bit. Every later bit is taken one bit period apart, at its centre.

Five sticky status flags are kept. One reports that the queue has reached a selectable fill threshold. One reports that a few characters have been waiting with no new traffic. One reports a receive error. One reports a line break and one reports an overrun. Each flag is cleared only by its own bit in a clear strobe vector. The flags feed three registered interrupt requests: data, receive error, and break/overrun. Each request is qualified by its own combination of two enable inputs.

While the break flag or the overrun flag is set, no new character enters the queue. Frames that have a framing or parity fault do not stop reception.

Top module: `uart_fifo_rx`

## Requirements
- R1: A start bit is recognised on a high-to-low transition of the line. It is confirmed by a sample taken 8 ticks later. If that sample is high, the event is discarded, nothing is stored and the receiver goes back to waiting for a falling edge.
- R2: Data bits arrive least significant bit first. With `cfg_len7`=1, seven bits are received and stored with bit 7 equal to 0. With `cfg_len7`=0, eight bits are received.
- R3: With `cfg_par_en`=1, a parity bit follows the data. The parity is even when `cfg_par_odd`=0 and odd when it is 1. A mismatch is stored as `rd_perr`=1 alongside the character and sets the error flag, `flags[2]`.
- R4: Only the first stop bit is checked. If it is 0, `rd_ferr`=1 is stored and `flags[2]` is set. With `cfg_two_stop`=1, the value of the second stop bit has no effect.
- R5: After a frame with a parity or framing fault, the next frame is received and stored normally.
- R6: The queue keeps characters in arrival order. Pulsing `rd_en` for one cycle while the queue is non-empty presents the oldest entry on `rd_data`/`rd_perr`/`rd_ferr` from the next cycle and lowers `rx_level` by one. These outputs do not change when `rd_en` is low.
- R7: A frame that completes while the queue holds DEPTH entries sets the overrun flag, `flags[4]`, and the character is dropped. While `flags[4]` is set, no character is stored.
- R8: A frame whose data bits, parity bit (if enabled) and first stop bit are all 0 is a break. It sets `flags[3]` and `flags[2]`, and it is not stored. While `flags[3]` is set, no character is stored.
- R9: The threshold flag, `flags[0]`, is set while `rx_level` is at or above the level chosen by `cfg_trig`: 0→1, 1→4, 2→8, 3→14. After a clear, it stays low while the level is below the threshold.
- R10: The data-ready flag, `flags[1]`, is set when 15 bit times (240 ticks) pass without a confirmed start bit while the queue is non-empty and below the threshold. It is not set while the level is at or above the threshold.
- R11: All five flags reset to 0. Once set, a flag stays set until the matching bit of `flag_clr` is pulsed (bit n clears `flags[n]`). Other clear bits leave it alone.
- R12: The interrupt requests are registered. `irq_data` is `ie_data` AND (`flags[0]` OR `flags[1]`). `irq_err` is (`ie_data` OR `ie_err`) AND `flags[2]`. `irq_brk` is (`ie_data` OR `ie_err`) AND (`flags[3]` OR `flags[4]`). All three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_len7 | input | 1 | 1 selects seven data bits |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_trig | input | 2 | Threshold select (1/4/8/14) |
| rd_en | input | 1 | Pop one entry from the queue |
| rd_data | output | DATA_W | Popped character |
| rd_perr | output | 1 | Parity fault of the popped character |
| rd_ferr | output | 1 | Stop-bit fault of the popped character |
| rx_level | output | clog2(DEPTH+1) | Queue fill count |
| flags | output | 5 | Sticky flags: 0 threshold, 1 ready, 2 error, 3 break, 4 overrun |
| flag_clr | input | 5 | Per-flag clear strobes |
| ie_data | input | 1 | Data interrupt enable |
| ie_err | input | 1 | Error interrupt enable |
| irq_data | output | 1 | Data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_brk | output | 1 | Break/overrun interrupt request |

## Verification
The bench builds the block with its default parameters: 8 data bits, a 16-entry queue, 16x oversampling and a 15-bit-time idle limit. It holds `tick16` high on every clock, so one bit lasts 16 clocks. With these values, filling the whole queue to reach overrun takes only a few thousand cycles, and the 240-tick idle window fits easily between frames. Every threshold code and both parity senses can therefore be exercised in short directed scenarios.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP1,
    S_STOP2
  } rx_state_e;

  localparam int FLG_TRIG  = 0;
  localparam int FLG_READY = 1;
  localparam int FLG_ERR   = 2;
  localparam int FLG_BRK   = 3;
  localparam int FLG_OVR   = 4;
  localparam int FLG_N     = 5;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  function automatic int trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_pin,
  input  frame_cfg_t        cfg,
  output logic              start_seen,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_perr,
  output logic              frame_ferr,
  output logic              frame_brk
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [1:0]        sync;
  logic              rx;
  logic              rx_last;
  rx_state_e         st;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [BW-1:0]     blast;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              any_one;
  logic              perr_q;

  assign rx    = sync[1];
  assign blast = cfg.len7 ? BW'(DATA_W - 2) : BW'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync       <= 2'b11;
      rx_last    <= 1'b1;
      st         <= S_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      shreg      <= '0;
      par_acc    <= 1'b0;
      any_one    <= 1'b0;
      perr_q     <= 1'b0;
      start_seen <= 1'b0;
      frame_done <= 1'b0;
      frame_data <= '0;
      frame_perr <= 1'b0;
      frame_ferr <= 1'b0;
      frame_brk  <= 1'b0;
    end else begin
      sync       <= {sync[0], rx_pin};
      start_seen <= 1'b0;
      frame_done <= 1'b0;
      if (tick) begin
        rx_last <= rx;
        tcnt    <= tcnt + 1'b1;
        case (st)
          S_IDLE: begin
            tcnt <= '0;
            if (rx_last && !rx) st <= S_START;
          end
          S_START: begin
            if (tcnt == MID) begin
              tcnt <= '0;
              if (!rx) begin
                st         <= S_DATA;
                start_seen <= 1'b1;
                bidx       <= '0;
                shreg      <= '0;
                par_acc    <= 1'b0;
                any_one    <= 1'b0;
                perr_q     <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_DATA: begin
            if (tcnt == LAST) begin
              tcnt        <= '0;
              shreg[bidx] <= rx;
              par_acc     <= par_acc ^ rx;
              any_one     <= any_one | rx;
              if (bidx == blast) st <= cfg.par_en ? S_PAR : S_STOP1;
              else               bidx <= bidx + 1'b1;
            end
          end
          S_PAR: begin
            if (tcnt == LAST) begin
              tcnt    <= '0;
              perr_q  <= (par_acc ^ rx) != cfg.par_odd;
              any_one <= any_one | rx;
              st      <= S_STOP1;
            end
          end
          S_STOP1: begin
            if (tcnt == LAST) begin
              tcnt       <= '0;
              frame_data <= shreg;
              frame_perr <= perr_q;
              frame_ferr <= !rx;
              frame_brk  <= !any_one && !rx;
              if (cfg.two_stop) begin
                st <= S_STOP2;
              end else begin
                st         <= S_IDLE;
                frame_done <= 1'b1;
              end
            end
          end
          S_STOP2: begin
            if (tcnt == LAST) begin
              tcnt       <= '0;
              st         <= S_IDLE;
              frame_done <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter  int W     = 10,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  din,
  input  logic          rd_en,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic          do_wr;
  logic          do_rd;

  assign full  = (level == LW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && (level != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (do_rd) begin
      dout <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter  int DEPTH   = 16,
  parameter  int OVS     = 16,
  parameter  int TO_BITS = 15,
  localparam int LW      = $clog2(DEPTH + 1),
  localparam int TO_LIM  = TO_BITS * OVS,
  localparam int TW      = $clog2(TO_LIM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start_seen,
  input  logic             frame_done,
  input  logic             frame_perr,
  input  logic             frame_ferr,
  input  logic             frame_brk,
  input  logic [LW-1:0]    level,
  input  logic             fifo_full,
  input  logic [1:0]       trig_sel,
  input  logic [FLG_N-1:0] clr,
  input  logic             ie_data,
  input  logic             ie_err,
  output logic             wr_accept,
  output logic [FLG_N-1:0] flags,
  output logic             irq_data,
  output logic             irq_err,
  output logic             irq_brk
);

  logic [TW-1:0]    idle_cnt;
  logic [FLG_N-1:0] set_v;
  int               thr;
  logic             at_thr;

  assign thr    = trig_level(trig_sel);
  assign at_thr = int'(level) >= thr;

  assign wr_accept = frame_done && !frame_brk && !fifo_full
                     && !flags[FLG_OVR] && !flags[FLG_BRK];

  always_comb begin
    set_v            = '0;
    set_v[FLG_TRIG]  = at_thr;
    set_v[FLG_READY] = (idle_cnt == TW'(TO_LIM)) && (level != '0) && !at_thr;
    set_v[FLG_ERR]   = frame_done && (frame_perr || frame_ferr);
    set_v[FLG_BRK]   = frame_done && frame_brk;
    set_v[FLG_OVR]   = frame_done && !frame_brk && fifo_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
    end else if (start_seen) begin
      idle_cnt <= '0;
    end else if (tick && idle_cnt != TW'(TO_LIM)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      irq_data <= 1'b0;
      irq_err  <= 1'b0;
      irq_brk  <= 1'b0;
    end else begin
      flags    <= (flags & ~clr) | set_v;
      irq_data <= ie_data && (flags[FLG_TRIG] || flags[FLG_READY]);
      irq_err  <= (ie_data || ie_err) && flags[FLG_ERR];
      irq_brk  <= (ie_data || ie_err) && (flags[FLG_BRK] || flags[FLG_OVR]);
    end
  end

endmodule

// File: rtl/uart_fifo_rx.sv
module uart_fifo_rx
  import uart_rx_pkg::*;
#(
  parameter  int DATA_W  = 8,
  parameter  int DEPTH   = 16,
  parameter  int OVS     = 16,
  parameter  int TO_BITS = 15,
  localparam int LW      = $clog2(DEPTH + 1),
  localparam int EW      = DATA_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_pin,
  input  logic             tick16,
  input  logic             cfg_len7,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic [1:0]       cfg_trig,
  input  logic             rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic             rd_perr,
  output logic             rd_ferr,
  output logic [LW-1:0]    rx_level,
  output logic [FLG_N-1:0] flags,
  input  logic [FLG_N-1:0] flag_clr,
  input  logic             ie_data,
  input  logic             ie_err,
  output logic             irq_data,
  output logic             irq_err,
  output logic             irq_brk
);

  frame_cfg_t        cfg;
  logic              start_seen;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_perr;
  logic              frame_ferr;
  logic              frame_brk;
  logic              wr_accept;
  logic              fifo_full;
  logic [EW-1:0]     fifo_dout;

  assign cfg = '{len7: cfg_len7, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, two_stop: cfg_two_stop};

  uart_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .rx_pin     (rx_pin),
    .cfg        (cfg),
    .start_seen (start_seen),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .frame_perr (frame_perr),
    .frame_ferr (frame_ferr),
    .frame_brk  (frame_brk)
  );

  uart_rx_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_accept),
    .din   ({frame_perr, frame_ferr, frame_data}),
    .rd_en (rd_en),
    .dout  (fifo_dout),
    .level (rx_level),
    .full  (fifo_full)
  );

  uart_rx_flags #(.DEPTH(DEPTH), .OVS(OVS), .TO_BITS(TO_BITS)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .start_seen (start_seen),
    .frame_done (frame_done),
    .frame_perr (frame_perr),
    .frame_ferr (frame_ferr),
    .frame_brk  (frame_brk),
    .level      (rx_level),
    .fifo_full  (fifo_full),
    .trig_sel   (cfg_trig),
    .clr        (flag_clr),
    .ie_data    (ie_data),
    .ie_err     (ie_err),
    .wr_accept  (wr_accept),
    .flags      (flags),
    .irq_data   (irq_data),
    .irq_err    (irq_err),
    .irq_brk    (irq_brk)
  );

  assign rd_data = fifo_dout[DATA_W-1:0];
  assign rd_ferr = fifo_dout[DATA_W];
  assign rd_perr = fifo_dout[DATA_W+1];

endmodule

// File: rtl/uart_fifo_rx_chk.sv
module uart_fifo_rx_chk #(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 16,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_perr,
  input logic              rd_ferr,
  input logic [LW-1:0]     rx_level,
  input logic [4:0]        flags,
  input logic [4:0]        flag_clr,
  input logic              ie_data,
  input logic              ie_err,
  input logic              irq_data,
  input logic              irq_err,
  input logic              irq_brk
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(rx_level) <= DEPTH); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable({rd_perr, rd_ferr, rd_data})); // R6

  AST_NO_GROW_ON_BRK: assert property (@(posedge clk) disable iff (rst)
    flags[3] |=> rx_level <= $past(rx_level)); // R8

  AST_NO_GROW_ON_OVR: assert property (@(posedge clk) disable iff (rst)
    flags[4] |=> rx_level <= $past(rx_level)); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    flags[4] && !flag_clr[4] |=> flags[4]); // R11

  AST_IRQ_DATA_OFF: assert property (@(posedge clk) disable iff (rst)
    !ie_data |=> !irq_data); // R12

  AST_IRQ_ERRS_OFF: assert property (@(posedge clk) disable iff (rst)
    !ie_data && !ie_err |=> !irq_err && !irq_brk); // R12

endmodule

bind uart_fifo_rx uart_fifo_rx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .rd_perr  (rd_perr),
  .rd_ferr  (rd_ferr),
  .rx_level (rx_level),
  .flags    (flags),
  .flag_clr (flag_clr),
  .ie_data  (ie_data),
  .ie_err   (ie_err),
  .irq_data (irq_data),
  .irq_err  (irq_err),
  .irq_brk  (irq_brk)
);

// File: tb/tb_uart_fifo_rx.sv
module tb_uart_fifo_rx;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int OVS    = 16;
  localparam int LW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst;
  logic              rx_pin;
  logic              tick16;
  logic              cfg_len7, cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic [1:0]        cfg_trig;
  logic              rd_en;
  logic [DATA_W-1:0] rd_data;
  logic              rd_perr, rd_ferr;
  logic [LW-1:0]     rx_level;
  logic [4:0]        flags;
  logic [4:0]        flag_clr;
  logic              ie_data, ie_err;
  logic              irq_data, irq_err, irq_brk;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] pd;
  logic       pp, pf;

  always #5 clk = ~clk;

  uart_fifo_rx dut (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .tick16(tick16),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_trig(cfg_trig), .rd_en(rd_en),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rx_level(rx_level), .flags(flags), .flag_clr(flag_clr),
    .ie_data(ie_data), .ie_err(ie_err),
    .irq_data(irq_data), .irq_err(irq_err), .irq_brk(irq_brk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] trig);
    rst = 1'b1; rx_pin = 1'b1; tick16 = 1'b1; rd_en = 1'b0; flag_clr = '0;
    cfg_len7 = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
    cfg_trig = trig; ie_data = 0; ie_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_out(input logic v);
    rx_pin = v;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par,
                            input logic stop1, input logic stop2);
    int nb;
    logic [7:0] dm;
    logic p;
    nb = cfg_len7 ? 7 : 8;
    dm = cfg_len7 ? {1'b0, d[6:0]} : d;
    p  = (^dm) ^ cfg_par_odd ^ bad_par;
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(dm[i]);
    if (cfg_par_en) bit_out(p);
    bit_out(stop1);
    if (cfg_two_stop) bit_out(stop2);
    rx_pin = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    send_frame(d, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic pop(output logic [7:0] d, output logic pe, output logic fe);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; pe = rd_perr; fe = rd_ferr;
  endtask

  task automatic clear(input logic [4:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic t_reset();
    do_reset(2'd3);
    chk("R11 flags after reset", 32'(flags), 0);
    chk("R6 level after reset", 32'(rx_level), 0);
    chk("R12 irqs after reset", {29'd0, irq_data, irq_err, irq_brk}, 0);
  endtask

  task automatic t_basic();
    do_reset(2'd3);
    send(8'hA5);
    send(8'h3C);
    chk("R6 level two frames", 32'(rx_level), 2);
    chk("R3 no error flag on clean frames", 32'(flags[2]), 0);
    pop(pd, pp, pf);
    chk("R2 first byte lsb first", 32'(pd), 32'hA5);
    chk("R3 clean status", {30'd0, pp, pf}, 0);
    pop(pd, pp, pf);
    chk("R6 second byte order", 32'(pd), 32'h3C);
    chk("R6 level drained", 32'(rx_level), 0);
  endtask

  task automatic t_parity();
    do_reset(2'd3);
    cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 0;
    send(8'hC1);
    pop(pd, pp, pf);
    chk("R2 seven-bit byte with bit7 zero", 32'(pd), 32'h41);
    chk("R3 even parity good", 32'(pp), 0);
    send_frame(8'h2A, 1'b1, 1'b1, 1'b1);
    chk("R3 error flag on bad parity", 32'(flags[2]), 1);
    send(8'h11);
    chk("R5 reception continues after parity fault", 32'(rx_level), 2);
    pop(pd, pp, pf);
    chk("R3 bad parity stored", {23'd0, pp, pd}, {23'd0, 1'b1, 8'h2A});
    pop(pd, pp, pf);
    chk("R5 next frame clean", {23'd0, pp, pd}, {23'd0, 1'b0, 8'h11});
    cfg_par_odd = 1;
    send(8'h40);
    pop(pd, pp, pf);
    chk("R3 odd parity good", {23'd0, pp, pd}, {23'd0, 1'b0, 8'h40});
  endtask

  task automatic t_stop();
    do_reset(2'd3);
    cfg_two_stop = 1;
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0);
    pop(pd, pp, pf);
    chk("R4 second stop ignored", {23'd0, pf, pd}, {23'd0, 1'b0, 8'h5A});
    chk("R4 no error flag from second stop", 32'(flags[2]), 0);
    send_frame(8'h66, 1'b0, 1'b0, 1'b1);
    chk("R4 error flag on bad first stop", 32'(flags[2]), 1);
    send(8'h77);
    chk("R5 frame after framing fault", 32'(rx_level), 2);
    pop(pd, pp, pf);
    chk("R4 framing fault stored", {23'd0, pf, pd}, {23'd0, 1'b1, 8'h66});
    pop(pd, pp, pf);
    chk("R5 clean frame after fault", {23'd0, pf, pd}, {23'd0, 1'b0, 8'h77});
  endtask

  task automatic t_glitch();
    do_reset(2'd3);
    rx_pin = 1'b0;
    repeat (5) @(negedge clk);
    rx_pin = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 glitch stores nothing", 32'(rx_level), 0);
    chk("R1 glitch sets no flag", 32'(flags), 0);
    send(8'h81);
    chk("R1 real frame after glitch", 32'(rx_level), 1);
    pop(pd, pp, pf);
    chk("R1 byte after glitch", 32'(pd), 32'h81);
  endtask

  task automatic t_break();
    do_reset(2'd3);
    send_frame(8'h00, 1'b0, 1'b0, 1'b1);
    chk("R8 break flag", 32'(flags[3]), 1);
    chk("R8 break also flags error", 32'(flags[2]), 1);
    chk("R8 break not stored", 32'(rx_level), 0);
    send(8'h12);
    chk("R8 write held off by break flag", 32'(rx_level), 0);
    clear(5'b01000);
    chk("R11 break flag cleared", 32'(flags[3]), 0);
    send(8'h34);
    chk("R8 write resumes after clear", 32'(rx_level), 1);
    pop(pd, pp, pf);
    chk("R8 byte after clear", 32'(pd), 32'h34);
  endtask

  task automatic t_overrun();
    do_reset(2'd3);
    for (int i = 0; i < DEPTH; i++) send(8'(8'h10 + i));
    chk("R7 queue full", 32'(rx_level), DEPTH);
    chk("R7 no overrun yet", 32'(flags[4]), 0);
    send(8'hEE);
    chk("R7 overrun flag", 32'(flags[4]), 1);
    chk("R7 level stays full", 32'(rx_level), DEPTH);
    pop(pd, pp, pf);
    chk("R7 oldest byte kept", 32'(pd), 32'h10);
    send(8'hDD);
    chk("R7 write held off by overrun flag", 32'(rx_level), DEPTH - 1);
    clear(5'b10000);
    chk("R11 overrun cleared", 32'(flags[4]), 0);
    send(8'hCC);
    chk("R7 write resumes", 32'(rx_level), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop(pd, pp, pf);
    chk("R7 last byte is post-clear frame", 32'(pd), 32'hCC);
  endtask

  task automatic t_trig();
    do_reset(2'd2);
    for (int i = 0; i < 7; i++) send(8'(i));
    chk("R9 below eight no trigger", 32'(flags[0]), 0);
    send(8'h07);
    chk("R9 trigger at eight", 32'(flags[0]), 1);
    for (int i = 0; i < 4; i++) pop(pd, pp, pf);
    clear(5'b00001);
    @(negedge clk);
    chk("R9 stays cleared below threshold", 32'(flags[0]), 0);
    do_reset(2'd0);
    send(8'h55);
    chk("R9 trigger at one", 32'(flags[0]), 1);
  endtask

  task automatic t_timeout();
    do_reset(2'd1);
    send(8'h42);
    chk("R10 no ready before idle window", 32'(flags[1]), 0);
    repeat (300) @(negedge clk);
    chk("R10 ready after idle window", 32'(flags[1]), 1);
    do_reset(2'd0);
    send(8'h43);
    repeat (300) @(negedge clk);
    chk("R10 no ready at threshold", 32'(flags[1:0]), 32'b01);
  endtask

  task automatic t_clear();
    do_reset(2'd3);
    cfg_par_en = 1;
    send_frame(8'h01, 1'b1, 1'b1, 1'b1);
    repeat (50) @(negedge clk);
    chk("R11 error flag sticky", 32'(flags[2]), 1);
    clear(5'b00001);
    chk("R11 other clear bit leaves error", 32'(flags[2]), 1);
    clear(5'b00100);
    chk("R11 own clear bit drops error", 32'(flags[2]), 0);
  endtask

  task automatic t_irq();
    do_reset(2'd0);
    cfg_par_en = 1; ie_err = 1;
    send_frame(8'h03, 1'b1, 1'b1, 1'b1);
    chk("R12 error irq with error enable", 32'(irq_err), 1);
    chk("R12 data irq masked", 32'(irq_data), 0);
    ie_data = 1;
    repeat (2) @(negedge clk);
    chk("R12 data irq with data enable", 32'(irq_data), 1);
    ie_data = 0;
    send_frame(8'h00, 1'b0, 1'b0, 1'b1);
    chk("R12 break irq with error enable", 32'(irq_brk), 1);
    ie_err = 0;
    repeat (2) @(negedge clk);
    chk("R12 all masked", {30'd0, irq_err, irq_brk}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_stop();
    t_glitch();
    t_break();
    t_overrun();
    t_trig();
    t_timeout();
    t_clear();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule